// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block provides the message-passing interrupt logic for a two-port shared memory holding 2^AW words. Two reserved addresses at the top of the address space act as mailboxes. The topmost address (all ones) belongs to the right port. The address one below it belongs to the left port. When one port writes into the other port's mailbox, the owner's interrupt flag is raised. The owner clears the flag by reading its own mailbox.

Each port presents an access enable, a write enable, an address and a BUSY indication from the external arbiter. Each port receives an active-low interrupt output. A port whose BUSY is active can neither raise the other side's flag nor clear its own. The mailbox data storage and the arbiter are outside this block. The block only watches accesses and keeps the two flags. The address width AW is a parameter and must be at least 2.

Top module: `mbox_irq`

## Requirements
- R1: After reset both interrupt outputs `l_irq_n` and `r_irq_n` are high (inactive).
- R2: A left write (`l_en`=1, `l_we`=1, `l_busy`=0) to address all-ones drives `r_irq_n` low from the next clock edge.
- R3: A right write (`r_en`=1, `r_we`=1, `r_busy`=0) to address all-ones minus one drives `l_irq_n` low from the next clock edge.
- R4: The owner clears its own flag by reading its own mailbox with BUSY low (`en`=1, `we`=0). The right port reads all-ones and the left port reads all-ones minus one. The output returns high after the next clock edge.
- R5: A port reading the other port's mailbox leaves that port's interrupt output unchanged.
- R6: A write into the other port's mailbox made while the writer's BUSY is high does not raise the other port's interrupt.
- R7: A read of a port's own mailbox made while that port's BUSY is high does not clear its interrupt.
- R8: If a flag is raised and cleared in the same cycle, raising takes priority and the output goes low.
- R9: These accesses have no effect on either flag: an access with `en`=0, a write to any address other than the other port's mailbox, and a write into a port's own mailbox.
- R10: With no qualifying access, each interrupt output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write (1) / read (0) |
| l_addr | input | AW | Left port address |
| l_busy | input | 1 | Left port BUSY from the arbiter |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_en | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write (1) / read (0) |
| r_addr | input | AW | Right port address |
| r_busy | input | 1 | Right port BUSY from the arbiter |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Each flag is a single register, so every set or clear appears on the interrupt output exactly one clock edge after the access is presented. The driver applies each access on a falling edge and queues the expected pair of outputs. The monitor pops that item shortly after the following rising edge, which is the first point where the result is due. The reset state is sampled once before any access is applied.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic          l_busy,
  output logic          l_irq_n,
  input  logic          r_en,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic          r_busy,
  output logic          r_irq_n
);
  localparam logic [AW-1:0] R_BOX = '1;
  localparam logic [AW-1:0] L_BOX = R_BOX - 1'b1;

  logic l_ok, r_ok;
  logic set_l, clr_l, set_r, clr_r;
  logic flag_l, flag_r;

  assign l_ok  = l_en & ~l_busy;
  assign r_ok  = r_en & ~r_busy;

  assign set_r = l_ok &  l_we & (l_addr == R_BOX);
  assign clr_r = r_ok & ~r_we & (r_addr == R_BOX);
  assign set_l = r_ok &  r_we & (r_addr == L_BOX);
  assign clr_l = l_ok & ~l_we & (l_addr == L_BOX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_l <= 1'b0;
      flag_r <= 1'b0;
    end else begin
      if (set_l)      flag_l <= 1'b1;
      else if (clr_l) flag_l <= 1'b0;
      if (set_r)      flag_r <= 1'b1;
      else if (clr_r) flag_r <= 1'b0;
    end
  end

  assign l_irq_n = ~flag_l;
  assign r_irq_n = ~flag_r;
endmodule

module mbox_irq_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_en,
  input logic          l_we,
  input logic [AW-1:0] l_addr,
  input logic          l_busy,
  input logic          l_irq_n,
  input logic          r_en,
  input logic          r_we,
  input logic [AW-1:0] r_addr,
  input logic          r_busy,
  input logic          r_irq_n
);
  localparam logic [AW-1:0] TOP = '1;
  localparam logic [AW-1:0] NXT = TOP - 1'b1;

  // R2, R8
  right_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && l_we && !l_busy && l_addr == TOP) |=> !r_irq_n);

  // R3, R8
  left_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && r_we && !r_busy && r_addr == NXT) |=> !l_irq_n);

  // R4
  right_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && !r_we && !r_busy && r_addr == TOP &&
     !(l_en && l_we && !l_busy && l_addr == TOP)) |=> r_irq_n);

  // R4
  left_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && !l_we && !l_busy && l_addr == NXT &&
     !(r_en && r_we && !r_busy && r_addr == NXT)) |=> l_irq_n);

  // R6
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && l_we && l_busy && r_irq_n) |=> r_irq_n);

  // R7
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && !r_we && r_busy && !r_irq_n) |=> !r_irq_n);
endmodule

bind mbox_irq mbox_irq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_busy(l_busy), .l_irq_n(l_irq_n),
  .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_busy(r_busy), .r_irq_n(r_irq_n)
);

// File: tb/tb_mbox_irq.sv
module tb_mbox_irq;
  localparam int AW = 5;
  localparam logic [AW-1:0] TOP = '1;
  localparam logic [AW-1:0] NXT = TOP - 1'b1;

  logic clk = 0, rst_n = 0;
  logic l_en = 0, l_we = 0, l_busy = 0, r_en = 0, r_we = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;

  int checks = 0, failures = 0;
  logic ml = 0, mr = 0;

  typedef struct { logic el; logic er; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  mbox_irq #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_busy(l_busy), .l_irq_n(l_irq_n),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_busy(r_busy), .r_irq_n(r_irq_n)
  );

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic step(input logic le, lw, input logic [AW-1:0] la, input logic lb,
                      input logic re, rw, input logic [AW-1:0] ra, input logic rb,
                      input string tag);
    logic nl, nr;
    exp_t e;
    @(negedge clk);
    l_en = le; l_we = lw; l_addr = la; l_busy = lb;
    r_en = re; r_we = rw; r_addr = ra; r_busy = rb;
    nl = ml; nr = mr;
    if (le && !lb && !lw && la == NXT) nl = 0;
    if (re && !rb && !rw && ra == TOP) nr = 0;
    if (le && !lb && lw && la == TOP) nr = 1;
    if (re && !rb && rw && ra == NXT) nl = 1;
    ml = nl; mr = nr;
    e.el = ~ml; e.er = ~mr; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (l_irq_n !== e.el || r_irq_n !== e.er) begin
        failures++;
        $display("FAIL %s: actual l=%b r=%b expected l=%b r=%b",
                 e.tag, l_irq_n, r_irq_n, e.el, e.er);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (l_irq_n !== 1'b1 || r_irq_n !== 1'b1) begin
      failures++;
      $display("FAIL R1 reset: actual l=%b r=%b expected l=1 r=1", l_irq_n, r_irq_n);
    end
    rst_n = 1;
    step(0,0,'0,0, 0,0,'0,0, "R1 idle after reset");
    step(1,1,TOP,0, 0,0,'0,0, "R2 left writes right mailbox");
    step(0,0,'0,0, 0,0,'0,0, "R10 hold");
    step(1,0,TOP,0, 0,0,'0,0, "R5 left reads right mailbox");
    step(0,0,'0,0, 1,1,TOP,0, "R9 right writes own mailbox");
    step(0,0,'0,0, 1,0,TOP,1, "R7 right busy read");
    step(0,0,'0,0, 1,0,TOP,0, "R4 right clears");
    step(0,0,'0,0, 1,1,NXT,1, "R6 right busy write");
    step(0,0,'0,0, 1,1,NXT,0, "R3 right writes left mailbox");
    step(0,0,'0,0, 1,0,NXT,0, "R5 right reads left mailbox");
    step(1,0,NXT,1, 0,0,'0,0, "R7 left busy read");
    step(1,0,NXT,0, 0,0,'0,0, "R4 left clears");
    step(0,1,TOP,0, 0,1,NXT,0, "R9 disabled writes");
    step(1,1,5'd3,0, 1,1,5'd7,0, "R9 other addresses");
    step(1,1,NXT,0, 0,0,'0,0, "R9 left writes own mailbox");
    step(1,1,TOP,1, 0,0,'0,0, "R6 left busy write");
    step(1,1,TOP,0, 1,0,TOP,0, "R8 right set and clear");
    step(1,0,NXT,0, 1,1,NXT,0, "R8 left set and clear");
    step(0,0,'0,0, 0,0,'0,0, "R10 both held");
    step(1,0,NXT,0, 1,0,TOP,0, "R4 both clear");
    step(0,0,'0,0, 0,0,'0,0, "R10 final");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule